// File: doc/BRIEF.md
# Programmable Oscillator Load Sequencer

This block programs an external frequency-synthesis oscillator that sits behind a small memory-mapped register bank. A host hands it six configuration bytes and a start pulse. The block then runs a fixed attempt made of register writes and timed settle waits. It sets up the control register, writes the six bytes, pulses a load trigger, reads the bytes back, pulses a reset trigger and returns the control register to enable-only. It then compares what it read with what it wrote.

If any byte read back differs from the byte written, the whole attempt is repeated, up to a bounded number of attempts. The outcome goes to the host as a one-cycle completion pulse, together with a held success or failure flag and the number of retries used. Each settle wait is a cycle count set by a parameter. At 125 MHz the default of 1,250,000 cycles gives 10 ms, which lies inside the 10 to 15 ms window the oscillator needs. Computing the configuration bytes and driving the oscillator's serial link are left to other logic.

Top module: `osc_prog_seq`

## Requirements
- R1: After reset, busy_o, done_o, ok_o, fail_o, bus_req_o and retries_o are all 0.
- R2: Each attempt issues exactly 17 bus transactions, in this order:
  - a control write of 0x00C0;
  - six byte writes;
  - a control write of 0x0240;
  - a control write of 0x00C0;
  - six byte reads;
  - a control write of 0x01C0;
  - a control write of 0x0040.
  All control writes go to address 0x04. In the control word, bit 9 is the load trigger, bit 8 the reset trigger, bit 7 host control and bit 6 enable.
- R3: Byte k (k = 0..5) is written to and read from address 0x08 + 4*k. Byte 0 is cfg_i[47:40] and byte 5 is cfg_i[7:0]. Write data is the byte zero-extended to 16 bits. cfg_i is sampled only when a start is accepted.
- R4: After each of the five control writes, bus_req_o stays low for exactly WAIT_CYCLES cycles before the next request, or before the attempt ends. Back-to-back transactions within a group have no idle cycle between them.
- R5: Only bits [7:0] of bus_rdata_i take part in the compare. Bits [15:8] have no effect on the outcome.
- R6: When all six readback bytes match, the block finishes with ok_o=1, fail_o=0 and retries_o equal to the number of attempts minus one.
- R7: On a mismatch the attempt is repeated, up to MAX_ATTEMPTS (3) attempts in total. If every attempt mismatches, the block finishes with fail_o=1, ok_o=0 and retries_o=MAX_ATTEMPTS-1.
- R8: busy_o is high from the cycle after an accepted start until the cycle in which done_o pulses. done_o is high for exactly one cycle. ok_o and fail_o hold their value until the next accepted start.
- R9: A start_i that arrives while busy_o=1 is ignored: the sequence neither restarts nor picks up the new cfg_i.
- R10: A raised bus_req_o holds its value, together with bus_we_o, bus_addr_o and bus_wdata_o, until bus_ack_i is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted only when idle |
| cfg_i | input | 48 | Six configuration bytes, byte 0 in the top bits |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Last run verified |
| fail_o | output | 1 | Last run exhausted its attempts |
| retries_o | output | 2 | Retries used in the last run |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | 8 | Register byte address |
| bus_wdata_o | output | 16 | Write data |
| bus_ack_i | input | 1 | Transaction accepted; read data is valid in the same cycle |
| bus_rdata_i | input | 16 | Read data |

## Verification
The properties assume that the bus slave raises bus_ack_i only while bus_req_o is high, and only for one cycle per transaction. They also assume that start_i is a single-cycle pulse. The stimulus model acknowledges each request after a random delay of 0 to 2 cycles and then drops the acknowledge. It returns random upper read bits, and it corrupts chosen low bytes only in the attempts picked to fail. Start pulses are driven one cycle wide, and that includes the deliberate pulse sent while the block is busy.

// File: rtl/osc_seq_pkg.sv
package osc_seq_pkg;
  localparam int NBYTES      = 6;
  localparam int BYTE_W      = 8;
  localparam int IDX_W       = $clog2(NBYTES);
  localparam int NSTEPS      = 2 * NBYTES + 10;
  localparam int STEP_W      = $clog2(NSTEPS);
  localparam int CTRL_W      = 16;
  localparam int CTRL_OFS    = 4;
  localparam int BYTE_OFS    = 8;
  localparam int BYTE_STRIDE = 4;

  localparam int B_LOAD  = 9;
  localparam int B_RESET = 8;
  localparam int B_HOST  = 7;
  localparam int B_EN    = 6;

  localparam logic [CTRL_W-1:0] W_EN    = CTRL_W'(1 << B_EN);
  localparam logic [CTRL_W-1:0] W_HOST  = W_EN | CTRL_W'(1 << B_HOST);
  localparam logic [CTRL_W-1:0] W_LOAD  = W_EN | CTRL_W'(1 << B_LOAD);
  localparam logic [CTRL_W-1:0] W_RESET = W_HOST | CTRL_W'(1 << B_RESET);

  typedef enum logic [1:0] {K_CTRL, K_WBYTE, K_RBYTE, K_WAIT} kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [CTRL_W-1:0] word;
    logic [IDX_W-1:0]  idx;
  } step_t;

  // step map: ctrl, wait, N writes, load, wait, host, wait, N reads, reset, wait, enable, wait
  function automatic step_t step_decode(input logic [STEP_W-1:0] s);
    int    n;
    step_t r;
    n      = int'(s);
    r.kind = K_WAIT;
    r.word = '0;
    r.idx  = '0;
    if (n == 0 || n == NBYTES + 4) begin
      r.kind = K_CTRL;
      r.word = W_HOST;
    end else if (n == NBYTES + 2) begin
      r.kind = K_CTRL;
      r.word = W_LOAD;
    end else if (n == 2 * NBYTES + 6) begin
      r.kind = K_CTRL;
      r.word = W_RESET;
    end else if (n == 2 * NBYTES + 8) begin
      r.kind = K_CTRL;
      r.word = W_EN;
    end else if (n >= 2 && n < 2 + NBYTES) begin
      r.kind = K_WBYTE;
      r.idx  = IDX_W'(n - 2);
    end else if (n >= NBYTES + 6 && n < 2 * NBYTES + 6) begin
      r.kind = K_RBYTE;
      r.idx  = IDX_W'(n - NBYTES - 6);
    end
    return r;
  endfunction
endpackage

// File: rtl/osc_seq_timer.sv
module osc_seq_timer #(
  parameter int CYCLES = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(CYCLES - 1);
    end else if (active_q) begin
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  assign expired_o = active_q && (cnt_q == '0);
endmodule

// File: rtl/osc_seq_verify.sv
module osc_seq_verify
  import osc_seq_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     chk_i,
  input  logic [IDX_W-1:0]         idx_i,
  input  logic [BYTE_W-1:0]        rd_lo_i,
  input  logic [NBYTES*BYTE_W-1:0] cfg_i,
  output logic                     mismatch_o
);
  logic [BYTE_W-1:0] exp_b [NBYTES];

  for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
    assign exp_b[g] = cfg_i[(NBYTES-1-g)*BYTE_W +: BYTE_W];
  end

  logic hit_bad;
  always_comb begin
    hit_bad = 1'b0;
    for (int k = 0; k < NBYTES; k++)
      if (idx_i == IDX_W'(k) && rd_lo_i != exp_b[k]) hit_bad = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mismatch_o <= 1'b0;
    else if (clear_i)           mismatch_o <= 1'b0;
    else if (chk_i && hit_bad)  mismatch_o <= 1'b1;
  end
endmodule

// File: rtl/osc_prog_seq.sv
module osc_prog_seq
  import osc_seq_pkg::*;
#(
  parameter int WAIT_CYCLES  = 1250000,
  parameter int MAX_ATTEMPTS = 3,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  localparam int RW          = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [NBYTES*BYTE_W-1:0] cfg_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     ok_o,
  output logic                     fail_o,
  output logic [RW-1:0]            retries_o,
  output logic                     bus_req_o,
  output logic                     bus_we_o,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [DATA_W-1:0]        bus_wdata_o,
  input  logic                     bus_ack_i,
  input  logic [DATA_W-1:0]        bus_rdata_i
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_WAIT} state_e;

  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(NSTEPS - 1);
  localparam logic [RW-1:0]     ATT_LAST  = RW'(MAX_ATTEMPTS - 1);

  state_e                   state_q;
  logic [STEP_W-1:0]        step_q;
  logic [RW-1:0]            att_q;
  logic [NBYTES*BYTE_W-1:0] cfg_q;
  logic                     done_q, ok_q, fail_q;
  logic [RW-1:0]            retries_q;

  step_t             cur, nxt;
  logic [STEP_W-1:0] step_nx;
  logic              accept, acked, tmr_load, tmr_exp, mism;
  logic              at_end, retry_go, vclear;

  assign step_nx = step_q + 1'b1;

  always_comb begin
    cur = step_decode(step_q);
    nxt = step_decode(step_nx);
  end

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign acked    = (state_q == ST_BUS) && bus_ack_i;
  assign tmr_load = acked && (nxt.kind == K_WAIT);
  assign at_end   = (state_q == ST_WAIT) && tmr_exp && (step_q == STEP_LAST);
  assign retry_go = at_end && mism && (att_q != ATT_LAST);
  assign vclear   = accept || retry_go;

  // bus drive, held steady by the registered step
  always_comb begin
    bus_req_o   = (state_q == ST_BUS);
    bus_we_o    = (cur.kind != K_RBYTE);
    bus_addr_o  = ADDR_W'(CTRL_OFS);
    bus_wdata_o = DATA_W'(cur.word);
    if (cur.kind != K_CTRL) begin
      bus_addr_o  = ADDR_W'(BYTE_OFS + BYTE_STRIDE * int'(cur.idx));
      bus_wdata_o = '0;
      for (int k = 0; k < NBYTES; k++)
        if (cur.idx == IDX_W'(k))
          bus_wdata_o = DATA_W'(cfg_q[(NBYTES-1-k)*BYTE_W +: BYTE_W]);
    end
  end

  osc_seq_timer #(.CYCLES(WAIT_CYCLES)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .expired_o(tmr_exp)
  );

  osc_seq_verify u_vfy (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (vclear),
    .chk_i     (acked && (cur.kind == K_RBYTE)),
    .idx_i     (cur.idx),
    .rd_lo_i   (bus_rdata_i[BYTE_W-1:0]),
    .cfg_i     (cfg_q),
    .mismatch_o(mism)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      att_q     <= '0;
      cfg_q     <= '0;
      done_q    <= 1'b0;
      ok_q      <= 1'b0;
      fail_q    <= 1'b0;
      retries_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cfg_q     <= cfg_i;
          step_q    <= '0;
          att_q     <= '0;
          ok_q      <= 1'b0;
          fail_q    <= 1'b0;
          retries_q <= '0;
          state_q   <= ST_BUS;
        end
        ST_BUS: if (bus_ack_i) begin
          step_q  <= step_nx;
          state_q <= (nxt.kind == K_WAIT) ? ST_WAIT : ST_BUS;
        end
        ST_WAIT: if (tmr_exp) begin
          if (step_q != STEP_LAST) begin
            step_q  <= step_nx;
            state_q <= ST_BUS;
          end else if (retry_go) begin
            att_q   <= att_q + 1'b1;
            step_q  <= '0;
            state_q <= ST_BUS;
          end else begin
            done_q    <= 1'b1;
            ok_q      <= !mism;
            fail_q    <= mism;
            retries_q <= att_q;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign ok_o      = ok_q;
  assign fail_o    = fail_q;
  assign retries_o = retries_q;
endmodule

// File: rtl/osc_prog_seq_chk.sv
module osc_prog_seq_chk #(
  parameter int MAX_ATTEMPTS = 3,
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 16,
  parameter int RW           = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              ok_o,
  input logic              fail_o,
  input logic [RW-1:0]     retries_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i
);
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) &&
                                $stable(bus_addr_o) && $stable(bus_wdata_o));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_req_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o);

  p_ok_xor_fail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ok_o != fail_o));

  p_retry_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> retries_o < RW'(MAX_ATTEMPTS));

  p_fail_retries_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fail_o |-> retries_o == RW'(MAX_ATTEMPTS - 1));

  p_ctrl_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_addr_o == ADDR_W'(4) |-> bus_we_o && bus_wdata_o[6]);

  p_read_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_we_o |-> bus_addr_o >= ADDR_W'(8) && bus_addr_o <= ADDR_W'(28) &&
                               bus_addr_o[1:0] == 2'b00);
endmodule

bind osc_prog_seq osc_prog_seq_chk #(
  .MAX_ATTEMPTS(MAX_ATTEMPTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RW(RW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o),
  .fail_o(fail_o), .retries_o(retries_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
  .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i)
);

// File: tb/sim_osc_prog_seq.sv
module sim_osc_prog_seq;
  localparam int WAITC = 12;
  localparam int NTX   = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] cfg = '0;
  logic        busy, done, ok, fail;
  logic [1:0]  retries;
  logic        req, we, ack;
  logic [7:0]  addr;
  logic [15:0] wdata, rdata;

  int n_run = 0, n_bad = 0, cyc = 0;

  always #4 clk = ~clk;

  osc_prog_seq #(.WAIT_CYCLES(WAITC), .MAX_ATTEMPTS(3)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cfg_i(cfg),
    .busy_o(busy), .done_o(done), .ok_o(ok), .fail_o(fail), .retries_o(retries),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata)
  );

  task automatic chk(input bit c, input string rq, input longint act, input longint exp);
    n_run++;
    if (!c) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // expected k-th transaction of an attempt
  function automatic void exp_tx(input int k, input logic [47:0] c,
                                 output bit w, output logic [7:0] a, output logic [15:0] d);
    w = 1'b1; a = 8'h04; d = 16'h0;
    if (k == 0 || k == 8)       d = 16'h00C0;
    else if (k == 7)            d = 16'h0240;
    else if (k == 15)           d = 16'h01C0;
    else if (k == 16)           d = 16'h0040;
    else if (k >= 1 && k <= 6) begin
      a = 8'(8 + 4 * (k - 1)); d = {8'h0, c[(6-k)*8 +: 8]};
    end else begin
      w = 1'b0; a = 8'(8 + 4 * (k - 9));
    end
  endfunction

  function automatic bit wait_after(input int k);
    return k == 0 || k == 7 || k == 8 || k == 15 || k == 16;
  endfunction

  logic [47:0] exp_cfg;
  int  bad_n, bad_byte, bad_bit, txn, lat, gap;
  bit  in_tx, have_prev;
  logic [7:0] mem [8];

  always @(negedge clk) begin
    bit ew; logic [7:0] ea; logic [15:0] ed; int k;
    if (!rst_n) begin
      ack = 1'b0; rdata = '0; in_tx = 0; gap = 0;
    end else begin
      if (ack) ack = 1'b0;
      if (req) begin
        if (!in_tx) begin
          in_tx = 1;
          lat = int'($urandom % 3);
          if (have_prev) begin
            k = (txn - 1) % NTX;
            chk(gap == (wait_after(k) ? WAITC : 0), "R4 gap", gap, wait_after(k) ? WAITC : 0);
          end
        end
        if (lat == 0) begin
          k = txn % NTX;
          exp_tx(k, exp_cfg, ew, ea, ed);
          chk(we == ew && addr == ea, "R2 op/addr", {we, addr}, {ew, ea});
          if (ew) chk(wdata == ed, "R3 wdata", wdata, ed);
          if (we && addr >= 8) mem[(addr - 8) >> 2] = wdata[7:0];
          if (!we) begin
            rdata = {8'($urandom), mem[(addr - 8) >> 2]};
            if (txn / NTX < bad_n && (addr - 8) >> 2 == bad_byte)
              rdata[bad_bit] = ~rdata[bad_bit];
          end
          ack = 1'b1; in_tx = 0; have_prev = 1; gap = 0; txn++;
        end else lat--;
      end else if (busy) gap++;
    end
  end

  task automatic run(input logic [47:0] c, input int bad, input bit poke);
    int t; int att;
    exp_cfg = c; bad_n = bad; bad_byte = int'($urandom % 6); bad_bit = int'($urandom % 8);
    txn = 0; have_prev = 0;
    @(negedge clk); start = 1'b1; cfg = c;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    t = 0;
    while (!done) begin
      @(negedge clk); t++;
      if (poke && t == 30) begin start = 1'b1; cfg = ~c; end
      if (poke && t == 31) start = 1'b0;
    end
    att = (bad < 3) ? bad + 1 : 3;
    if (poke) chk(busy == 1'b0, "R9 busy start ignored", busy, 0);
    chk(txn == att * NTX, "R7 txn count", txn, att * NTX);
    chk(ok == (bad < 3), "R6 ok", ok, bad < 3);
    chk(fail == (bad == 3), "R7 fail", fail, bad == 3);
    chk(retries == 2'(att - 1), "R6 retries", retries, att - 1);
    chk(gap == WAITC, "R4 final wait", gap, WAITC);
    @(negedge clk);
    chk(done == 1'b0, "R8 done pulse", done, 0);
    chk(ok == (bad < 3) && !busy, "R8 ok held", ok, bad < 3);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_run++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ok && !fail && !req && retries == 0, "R1 reset",
        {busy, done, ok, fail, req, retries}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !req, "R1 idle after reset", {busy, req}, 0);
    run(48'h0, 0, 0);                        // R6 all-zero bytes
    run(48'hFFFF_FFFF_FFFF, 0, 0);           // R5 upper read bits random
    run(48'h0123_4567_89AB, 1, 0);           // R7 one retry
    run(48'hA5C3_0F7E_1D22, 2, 0);           // R7 two retries
    run(48'h5A5A_5A5A_5A5A, 3, 0);           // R7 exhausted
    run(48'h1122_3344_5566, 0, 1);           // R9 start while busy
    run(48'h6655_4433_2211, 3, 1);           // R9 during failing run
    for (int i = 0; i < 8; i++)
      run({$urandom, 16'($urandom)}, int'($urandom % 4), 1'($urandom));
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule